// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of a synchronous DRAM alive by requesting auto-refresh commands at a steady rate. A free-running interval timer counts clocks up to the per-row refresh spacing. That spacing is the retention period divided by the number of rows, and it is computed from the clock rate when the design is elaborated. Each expiry adds one to a small owed-refresh count. A state machine works through that count one refresh at a time. It reaches the command sequencer through two request/grant pairs: one that asks for all banks to be closed, and one that asks for the refresh itself. It moves a row pointer forward each time the sequencer reports that a refresh has finished.

The sequencer may need several intervals before it can serve a request, for example during a long burst or while the device is in a low-power state. In that case the owed count keeps growing, up to a cap, so that no refresh is lost. When the device leaves self-refresh, the scheduler first waits a fixed number of idle cycles. It then performs a refresh of every row back to back, and after that it starts the interval count again from zero.

States: `ST_IDLE` (nothing owed, or refresh blocked), `ST_PRECH` (asking for all banks to be closed), `ST_CLOSE` (close granted, waiting for the banks to report closed), `ST_REQ` (asking for a refresh), `ST_BUSY` (refresh granted, waiting for completion; the sequencer issues only NOPs), `ST_HOLD` (idle cycles after leaving self-refresh). Transitions:
- IDLE to HOLD on a self-refresh exit pulse.
- IDLE to PRECH when work is due and a bank is open.
- IDLE to REQ when work is due and all banks are closed.
- PRECH to CLOSE on the close grant.
- CLOSE to REQ once no bank is open.
- REQ to BUSY on the refresh grant.
- BUSY to IDLE on refresh completion.
- HOLD to IDLE when the idle count runs out, with the full-array burst armed.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With requests served at once, successive rising edges of `ref_req` are exactly INTERVAL = (CLK_KHZ*RETAIN_MS)/ROW_COUNT cycles apart, using integer division.
- R2: Once raised, `ref_req` stays high until `ref_gnt` is seen. After the grant, no new `ref_req` is raised until `ref_done` arrives, even if further intervals expire in the meantime.
- R3: `row_ptr` advances by exactly one on each completed refresh and wraps from ROW_COUNT-1 to 0. It never changes without a `ref_done` in the busy state.
- R4: No refresh cycle is started while `low_power` is high. `ref_req` never rises in a cycle that follows one with `banks_open` high.
- R5: When a refresh is due and `banks_open` is high, `pre_req` is raised first and `ref_req` stays low. `pre_req` is held until `pre_gnt`. `ref_req` is raised only once `banks_open` has fallen. `pre_req` and `ref_req` are never high together.
- R6: Every expired interval adds one to `pending`, which saturates at PEND_MAX (8). Each completed normal refresh subtracts one, so the owed refreshes are issued one after another until `pending` is 0.
- R7: After an `sr_exit` pulse in the idle state, `ref_req` stays low for EXIT_NOPS cycles. Then exactly ROW_COUNT refreshes are requested back to back. After the last one, `pending` is 0 and the interval timer restarts from zero.
- R8: During and right after reset, `pre_req` and `ref_req` are low, and `row_ptr` and `pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| low_power | input | 1 | Device is in a low-power or self-refresh state; no refresh may start |
| banks_open | input | 1 | At least one bank has an active row |
| sr_exit | input | 1 | One-cycle pulse: the device has just left self-refresh |
| pre_gnt | input | 1 | Sequencer accepts the close-all-banks request |
| ref_gnt | input | 1 | Sequencer accepts the refresh request |
| ref_done | input | 1 | Refresh has finished and all banks are idle |
| pre_req | output | 1 | Request to close all banks |
| ref_req | output | 1 | Request for one auto-refresh |
| row_ptr | output | $clog2(ROW_COUNT) | Row that the next refresh covers |
| pending | output | $clog2(PEND_MAX+1) | Number of refreshes owed |

## Verification
The hardest state to reach from the ports is a saturated owed count whose drain can be counted exactly. Saturation has to line up with the phase of the interval timer, or a fresh expiry lands in the middle of the drain and changes the count. The stimulus holds `low_power` high and watches `pending` step from 7 to 8 to find the edge on which the timer expires. It waits one more full interval to show that the count holds at the cap. It then releases `low_power` right after the next expiry, so that all eight refreshes finish before the timer expires again. The full-array burst after self-refresh is handled the same way: the timer is restarted when the burst ends, which keeps an ordinary refresh out of the counting window.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_CLOSE,
        ST_REQ,
        ST_BUSY,
        ST_HOLD
    } rs_state_e;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rs_owe_counter.sv
module rs_owe_counter #(
    parameter int PEND_MAX = 8,
    localparam int PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [PW-1:0] count
);
    localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && !dec) begin
            if (count != CAP) count <= count + 1'b1;
        end else if (dec && !inc) begin
            if (count != '0) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
    parameter int CLK_KHZ   = 50000,
    parameter int RETAIN_MS = 64,
    parameter int ROW_COUNT = 8192,
    parameter int PEND_MAX  = 8,
    parameter int EXIT_NOPS = 8,
    localparam int ROW_W    = (ROW_COUNT > 1) ? $clog2(ROW_COUNT) : 1,
    localparam int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_power,
    input  logic              banks_open,
    input  logic              sr_exit,
    input  logic              pre_gnt,
    input  logic              ref_gnt,
    input  logic              ref_done,
    output logic              pre_req,
    output logic              ref_req,
    output logic [ROW_W-1:0]  row_ptr,
    output logic [PEND_W-1:0] pending
);
    import rs_pkg::*;

    localparam int INTERVAL = (CLK_KHZ * RETAIN_MS) / ROW_COUNT;
    localparam int BURST_W  = $clog2(ROW_COUNT + 1);
    localparam int NOP_W    = (EXIT_NOPS > 1) ? $clog2(EXIT_NOPS) : 1;
    localparam logic [NOP_W-1:0]   NOP_LAST  = NOP_W'(EXIT_NOPS - 1);
    localparam logic [ROW_W-1:0]   ROW_LAST  = ROW_W'(ROW_COUNT - 1);
    localparam logic [BURST_W-1:0] BURST_ALL = BURST_W'(ROW_COUNT);

    rs_state_e            state, nstate;
    logic [BURST_W-1:0]   burst_left;
    logic [NOP_W-1:0]     nop_cnt;
    logic                 tick;
    logic                 work_due;
    logic                 done_ev;
    logic                 burst_on;
    logic                 burst_last;
    logic                 exit_take;
    logic                 hold_end;
    logic                 restart;

    assign burst_on   = (burst_left != '0);
    assign work_due   = !low_power && (burst_on || (pending != '0));
    assign done_ev    = (state == ST_BUSY) && ref_done;
    assign burst_last = done_ev && (burst_left == BURST_W'(1));
    assign exit_take  = (state == ST_IDLE) && sr_exit;
    assign hold_end   = (state == ST_HOLD) && (nop_cnt == NOP_LAST);
    assign restart    = exit_take || burst_last;

    rs_interval_timer #(.INTERVAL(INTERVAL)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .tick  (tick)
    );

    rs_owe_counter #(.PEND_MAX(PEND_MAX)) i_owe (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .inc   (tick),
        .dec   (done_ev && !burst_on),
        .count (pending)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_exit)       nstate = ST_HOLD;
                else if (work_due) nstate = banks_open ? ST_PRECH : ST_REQ;
            end
            ST_PRECH: if (pre_gnt)     nstate = ST_CLOSE;
            ST_CLOSE: if (!banks_open) nstate = ST_REQ;
            ST_REQ:   if (ref_gnt)     nstate = ST_BUSY;
            ST_BUSY:  if (ref_done)    nstate = ST_IDLE;
            ST_HOLD:  if (hold_end)    nstate = ST_IDLE;
            default:                   nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        pre_req = (state == ST_PRECH);
        ref_req = (state == ST_REQ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_ptr    <= '0;
            burst_left <= '0;
            nop_cnt    <= '0;
        end else begin
            if (done_ev) begin
                row_ptr <= (row_ptr == ROW_LAST) ? '0 : row_ptr + 1'b1;
            end
            if (hold_end) begin
                burst_left <= BURST_ALL;
            end else if (done_ev && burst_on) begin
                burst_left <= burst_left - 1'b1;
            end
            nop_cnt <= (state == ST_HOLD) ? nop_cnt + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/rs_sched_checker.sv
module rs_sched_checker #(
    parameter int ROW_COUNT = 8192,
    parameter int PEND_MAX  = 8,
    localparam int ROW_W    = (ROW_COUNT > 1) ? $clog2(ROW_COUNT) : 1,
    localparam int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              low_power,
    input logic              banks_open,
    input logic              sr_exit,
    input logic              ref_gnt,
    input logic              ref_done,
    input logic              pre_req,
    input logic              ref_req,
    input logic [ROW_W-1:0]  row_ptr,
    input logic [PEND_W-1:0] pending
);
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ptr != $past(row_ptr)) |->
            (row_ptr == (($past(row_ptr) == ROW_W'(ROW_COUNT - 1)) ? '0 : $past(row_ptr) + 1'b1)));

    assert_no_req_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> !$past(banks_open));

    assert_excl_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_req && ref_req));

    assert_pend_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(PEND_MAX));

    assert_exit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_exit && !ref_req && !pre_req) |=> !ref_req);

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (!ref_req && !pre_req));

    logic unused_ok;
    assign unused_ok = low_power ^ ref_done;
endmodule

bind sdram_refresh_sched rs_sched_checker #(
    .ROW_COUNT (ROW_COUNT),
    .PEND_MAX  (PEND_MAX)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_power  (low_power),
    .banks_open (banks_open),
    .sr_exit    (sr_exit),
    .ref_gnt    (ref_gnt),
    .ref_done   (ref_done),
    .pre_req    (pre_req),
    .ref_req    (ref_req),
    .row_ptr    (row_ptr),
    .pending    (pending)
);

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
    localparam int CLK_KHZ   = 1000;
    localparam int RETAIN_MS = 1;
    localparam int ROWS      = 16;
    localparam int PMAX      = 8;
    localparam int NOPS      = 5;
    localparam int IVL       = (CLK_KHZ * RETAIN_MS) / ROWS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_power = 1'b0;
    logic       banks_open = 1'b0;
    logic       sr_exit = 1'b0;
    logic       pre_gnt = 1'b0;
    logic       ref_gnt = 1'b0;
    logic       ref_done = 1'b0;
    logic       pre_req, ref_req;
    logic [3:0] row_ptr;
    logic [3:0] pending;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  n_ref = 0;
    bit  gnt_ok = 1'b1;
    bit  done_ok = 1'b1;
    bit  pre_ok = 1'b1;
    bit  busy = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_sched #(
        .CLK_KHZ(CLK_KHZ), .RETAIN_MS(RETAIN_MS), .ROW_COUNT(ROWS),
        .PEND_MAX(PMAX), .EXIT_NOPS(NOPS)
    ) i_sdram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .low_power(low_power), .banks_open(banks_open),
        .sr_exit(sr_exit), .pre_gnt(pre_gnt), .ref_gnt(ref_gnt), .ref_done(ref_done),
        .pre_req(pre_req), .ref_req(ref_req), .row_ptr(row_ptr), .pending(pending)
    );

    // sequencer model: serves grants and completions on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (ref_gnt) begin
                ref_gnt = 1'b0;
                busy = 1'b1;
            end else if (busy && done_ok) begin
                ref_done = 1'b1;
                busy = 1'b0;
                n_ref++;
            end else if (ref_done) begin
                ref_done = 1'b0;
            end else if (ref_req && gnt_ok) begin
                ref_gnt = 1'b1;
            end
            if (pre_gnt) pre_gnt = 1'b0;
            else if (pre_req && pre_ok) pre_gnt = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_sig(input bit want_req, input int limit, output int waited);
        waited = 0;
        while (((want_req ? ref_req : pre_req) == 1'b0) && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle_cycles(3);
        check(!pre_req && !ref_req, "R8 requests low in reset", {pre_req, ref_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(row_ptr == 0, "R8 row_ptr after reset", row_ptr, 0);
        check(pending == 0 && !ref_req, "R8 pending after reset", pending, 0);
    endtask

    task automatic t_interval;
        int w, t0, t1, t2;
        logic [3:0] r0;
        wait_sig(1'b1, 3 * IVL, w);
        t0 = cyc;
        r0 = row_ptr;
        idle_cycles(8);
        check(row_ptr == 4'(r0 + 1), "R3 row_ptr step", row_ptr, r0 + 1);
        wait_sig(1'b1, 3 * IVL, w);
        t1 = cyc;
        idle_cycles(8);
        wait_sig(1'b1, 3 * IVL, w);
        t2 = cyc;
        check(t1 - t0 == IVL, "R1 first spacing", t1 - t0, IVL);
        check(t2 - t1 == IVL, "R1 second spacing", t2 - t1, IVL);
        idle_cycles(8);
    endtask

    task automatic t_handshake;
        int w;
        bit held = 1'b1;
        bit quiet = 1'b1;
        logic [3:0] r0;
        gnt_ok = 1'b0;
        done_ok = 1'b0;
        wait_sig(1'b1, 3 * IVL, w);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!ref_req) held = 1'b0;
        end
        check(held, "R2 ref_req held without grant", held, 1);
        r0 = row_ptr;
        gnt_ok = 1'b1;
        idle_cycles(2);
        for (int i = 0; i < IVL + 10; i++) begin
            @(negedge clk);
            if (ref_req) quiet = 1'b0;
        end
        check(quiet, "R2 no request while busy", quiet, 1);
        check(row_ptr == r0, "R3 row_ptr holds without done", row_ptr, r0);
        check(pending >= 1, "R6 missed interval kept", pending, 1);
        done_ok = 1'b1;
        idle_cycles(20);
        check(pending == 0, "R6 owed refreshes drained", pending, 0);
    endtask

    task automatic t_precharge;
        int w;
        bit held = 1'b1;
        bit noref = 1'b1;
        banks_open = 1'b1;
        pre_ok = 1'b0;
        wait_sig(1'b0, 3 * IVL, w);
        check(pre_req && !ref_req, "R5 close request first", {pre_req, ref_req}, 2);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!pre_req || ref_req) held = 1'b0;
        end
        check(held, "R5 pre_req held until grant", held, 1);
        pre_ok = 1'b1;
        idle_cycles(2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ref_req || pre_req) noref = 1'b0;
        end
        check(noref, "R5 no refresh while banks open", noref, 1);
        banks_open = 1'b0;
        wait_sig(1'b1, 4, w);
        check(ref_req && w <= 2, "R5 refresh after banks close", w, 1);
        idle_cycles(10);
    endtask

    task automatic t_lowpower;
        bit quiet = 1'b1;
        int base;
        low_power = 1'b1;
        while (pending != 4'd7) begin
            @(negedge clk);
            if (ref_req) quiet = 1'b0;
            if (cyc > 120000) break;
        end
        while (pending != 4'd8) begin
            @(negedge clk);
            if (ref_req) quiet = 1'b0;
            if (cyc > 120000) break;
        end
        for (int i = 0; i < IVL; i++) begin
            @(negedge clk);
            if (ref_req) quiet = 1'b0;
        end
        check(quiet, "R4 no request in low power", quiet, 1);
        check(pending == PMAX, "R6 saturated at cap", pending, PMAX);
        base = n_ref;
        low_power = 1'b0;
        idle_cycles(50);
        check(n_ref - base == PMAX, "R6 drain count", n_ref - base, PMAX);
        check(pending == 0, "R6 pending empty after drain", pending, 0);
    endtask

    task automatic t_selfref_exit;
        bit quiet = 1'b1;
        int base;
        logic [3:0] r0;
        low_power = 1'b1;
        idle_cycles(10);
        r0 = row_ptr;
        sr_exit = 1'b1;
        low_power = 1'b0;
        @(negedge clk);
        sr_exit = 1'b0;
        base = n_ref;
        for (int i = 0; i < NOPS; i++) begin
            @(negedge clk);
            if (ref_req) quiet = 1'b0;
        end
        check(quiet, "R7 quiet after exit", quiet, 1);
        idle_cycles(105);
        check(n_ref - base == ROWS, "R7 full burst count", n_ref - base, ROWS);
        check(row_ptr == r0, "R3 row_ptr wraps over burst", row_ptr, r0);
        check(pending == 0, "R7 pending cleared after burst", pending, 0);
    endtask

    initial begin
        t_reset();
        t_interval();
        t_handshake();
        t_precharge();
        t_lowpower();
        t_selfref_exit();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule